// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a 32-bit register window of 1 KiB. A write to the data word starts one 8-bit full-duplex exchange on the serial clock, output and input lines. The byte shifted in is queued in a small receive FIFO, and a read of the data word takes the oldest byte from that FIFO. Clock polarity, sampling phase, bit order and a power-of-two clock divider are chosen in the first control word. The divider and mode are captured when an exchange starts, so later control writes do not disturb an exchange already running.

An interrupt line reports "transmit side idle" (unconditionally, when its enable is set) and "receive FIFO holds data" (when its own enable is set). The line is a stored level. It is recomputed only at defined moments: a completed exchange, a write to the second control word, and a data read that actually removes a byte. Any other data access drops it, and so does turning the enable bit of the first control word from 1 to 0. A one-cycle receive-DMA request pulse accompanies every received byte while receive DMA is enabled. Word offsets 0x10 to 0x20 hold storage that has no effect on the shift engine, kept so that software sees the register values it expects.

Top module: `spi_master_mmio`

## Requirements
- R1: After reset, the status word (offset 0x8) reads 0x00000002, the control words read 0, `irq` and `dma_rx_req` are 0 and `sck` is 0.
- R2: The first control word (0x0) stores and reads back bits 15:0. The second control word (0x4) stores bits 7:0 and reads bits 31:8 as 0. Offset 0x10 resets to 0x0007 and stores 16 bits. Offset 0x20 resets to 0x0002 and stores 10 bits. Offsets 0x14, 0x18 and all unmapped offsets read 0.
- R3: Offset 0x1C stores bits 11:0, except that bit 10 always reads 0 whatever is written.
- R4: A data write (0xC) while idle sends bits 7:0 of the written word on `mosi`. Status bit 1 reads 0 for exactly 16·2^div clock cycles after the write edge, where div is control bits 5:3.
- R5: Control bit 1 sets the idle level of `sck`. With control bit 0 = 0, data is sampled on the first edge of each bit; with it = 1, data is sampled on the second edge. Control bit 7 = 1 sends and receives the least significant bit first; 0 sends and receives the most significant bit first.
- R6: Each completed exchange queues the received byte. Data reads return the queued bytes in arrival order in bits 7:0. Status bit 0 is 1 while the queue is non-empty.
- R7: A data read with an empty queue returns 0 and changes no status bit.
- R8: A data write while an exchange is in progress is dropped: it is not sent and queues nothing.
- R9: The queue holds 4 bytes. A byte received while it is full is discarded, and status bit 6 is set. Bit 6 is cleared only by a data read that follows a status read made while bit 6 was set.
- R10: `irq` is recomputed as TXEIE (ctrl2 bit 7) OR (queue non-empty AND RXNEIE, ctrl2 bit 6). This happens after a completed exchange, after a ctrl2 write, and after a data read that removes a byte.
- R11: A data write, and a data read of an empty queue, force `irq` to 0. A ctrl1 write that changes bit 6 from 1 to 0 also forces `irq` to 0.
- R12: With ctrl2 bit 0 set, each completed exchange produces exactly one single-cycle `dma_rx_req` pulse; with it clear, none.
- R13: When an exchange completes in the same cycle as a data read, the read returns the previous head byte and the new byte is still queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |
| dma_rx_req | output | 1 | One-cycle receive DMA request |

## Verification
Two events can fall on the same clock edge: the shift engine finishing an exchange, which pushes a byte, and a data read from the bus, which pops a byte. The bench times a data read so that it falls exactly on the final edge of a divide-by-one exchange while one byte is already queued. It then checks three things: the read returns the old head, the new byte remains queued with status bit 0 still set, and `irq` holds the recomputed level. A second overlap comes from a data write issued partway through an exchange. It is judged by the byte the bench's serial slave captured and by the queue depth afterwards.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // word indices (byte offset / 4) inside the 1 KiB window
  localparam logic [7:0] WI_CTRL_A = 8'd0;
  localparam logic [7:0] WI_CTRL_B = 8'd1;
  localparam logic [7:0] WI_STAT   = 8'd2;
  localparam logic [7:0] WI_DATA   = 8'd3;
  localparam logic [7:0] WI_POLY   = 8'd4;
  localparam logic [7:0] WI_RXSUM  = 8'd5;
  localparam logic [7:0] WI_TXSUM  = 8'd6;
  localparam logic [7:0] WI_AUDCFG = 8'd7;
  localparam logic [7:0] WI_AUDPRE = 8'd8;

  typedef struct packed {
    logic lsb_first;
    logic phase;
    logic polarity;
  } shift_mode_t;

  // system clocks per serial-clock half period
  function automatic int unsigned half_ticks(input int unsigned div);
    return 32'd1 << div;
  endfunction

  // level the interrupt takes when recomputed
  function automatic logic irq_level(input logic txeie, input logic rxneie,
                                     input logic nonempty);
    return txeie | (nonempty & rxneie);
  endfunction

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         nonempty_nxt,
  output logic         dropped
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, count_nxt;
  logic          full, pop_ok, push_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty        = (count == '0);
  assign full         = (count == CW'(DEPTH));
  assign pop_ok       = pop && !empty;
  assign push_ok      = push && (!full || pop_ok);
  assign dropped      = push && !push_ok;
  assign count_nxt    = count + CW'(push_ok) - CW'(pop_ok);
  assign nonempty_nxt = (count_nxt != '0);
  assign rdata        = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok) wr_ptr <= bump(wr_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  // R9
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> (count == CW'(DEPTH)));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
#(
  parameter int FRAME = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FRAME-1:0] tx_byte,
  input  shift_mode_t      mode,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [FRAME-1:0] rx_byte
);
  localparam int EDGES = 2 * FRAME;
  localparam int EW    = $clog2(EDGES);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic             busy_q, sck_q;
  shift_mode_t      mode_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q, half_m1;
  logic [EW-1:0]    edge_q;
  logic [FRAME-1:0] tx_sr, rx_sr, rx_nxt, tx_nxt;
  logic             tick, leading, sample_now, shift_now, last;

  assign half_m1    = CNT_W'(half_ticks(32'(div_q)) - 1);
  assign tick       = busy_q && (cnt_q == half_m1);
  assign leading    = ~edge_q[0];
  assign last       = (edge_q == EW'(EDGES - 1));
  assign sample_now = mode_q.phase ? ~leading : leading;
  assign shift_now  = mode_q.phase ? (leading && edge_q != '0) : ~leading;
  assign rx_nxt     = mode_q.lsb_first ? {miso, rx_sr[FRAME-1:1]}
                                       : {rx_sr[FRAME-2:0], miso};
  assign tx_nxt     = mode_q.lsb_first ? (tx_sr >> 1) : (tx_sr << 1);

  assign sck     = sck_q;
  assign mosi    = mode_q.lsb_first ? tx_sr[0] : tx_sr[FRAME-1];
  assign busy    = busy_q;
  assign done    = tick && last;
  assign rx_byte = sample_now ? rx_nxt : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mode_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      edge_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (!busy_q) begin
      sck_q <= mode.polarity;
      if (start) begin
        busy_q <= 1'b1;
        mode_q <= mode;
        div_q  <= div;
        tx_sr  <= tx_byte;
        rx_sr  <= '0;
        cnt_q  <= '0;
        edge_q <= '0;
      end
    end else if (tick) begin
      cnt_q  <= '0;
      sck_q  <= ~sck_q;
      edge_q <= edge_q + 1'b1;
      if (sample_now) rx_sr <= rx_nxt;
      if (shift_now)  tx_sr <= tx_nxt;
      if (last)       busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sck_q == mode_q.polarity));
  // R5
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sck_q));

endmodule

// File: rtl/spi_host_irq.sv
module spi_host_irq
  import spi_host_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_fall,
  input  logic ctrl_b_wr,
  input  logic xfer_done,
  input  logic data_rd,
  input  logic data_wr,
  input  logic rd_hit,
  input  logic txeie_nxt,
  input  logic rxneie_nxt,
  input  logic nonempty_nxt,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (en_fall)
      irq_d = 1'b0;
    else if (xfer_done || ctrl_b_wr || (data_rd && rd_hit))
      irq_d = irq_level(txeie_nxt, rxneie_nxt, nonempty_nxt);
    else if (data_rd || data_wr)
      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R11
  irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !irq_q);

endmodule

// File: rtl/spi_master_mmio.sv
module spi_master_mmio
  import spi_host_pkg::*;
#(
  parameter int FRAME      = 8,
  parameter int DIV_W      = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [9:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq,
  output logic        dma_rx_req
);
  logic [15:0] ctrl_a;
  logic [7:0]  ctrl_b;
  logic [15:0] poly_q;
  logic [11:0] aud_cfg;
  logic [9:0]  aud_pre;
  logic        ovf, ovf_armed, dma_q;

  logic [7:0]  widx;
  logic        wr_ctrl_a, wr_ctrl_b, wr_data, rd_stat, rd_data;
  logic        en_fall, start, busy, xfer_done;
  logic [FRAME-1:0] rx_byte, fifo_head;
  logic        fifo_empty, nonempty_nxt, fifo_drop;
  shift_mode_t mode;
  logic        unused_bits;

  assign widx      = bus_addr[9:2];
  assign wr_ctrl_a = bus_en && bus_we && (widx == WI_CTRL_A);
  assign wr_ctrl_b = bus_en && bus_we && (widx == WI_CTRL_B);
  assign wr_data   = bus_en && bus_we && (widx == WI_DATA);
  assign rd_stat   = bus_en && !bus_we && (widx == WI_STAT);
  assign rd_data   = bus_en && !bus_we && (widx == WI_DATA);

  assign en_fall   = wr_ctrl_a && ctrl_a[6] && !bus_wdata[6];
  assign start     = wr_data && !busy;
  assign mode      = '{lsb_first: ctrl_a[7], phase: ctrl_a[0], polarity: ctrl_a[1]};

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16], ctrl_a[2]};

  spi_host_shift #(.FRAME(FRAME), .DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_byte (bus_wdata[FRAME-1:0]),
    .mode    (mode),
    .div     (ctrl_a[3 +: DIV_W]),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (busy),
    .done    (xfer_done),
    .rx_byte (rx_byte)
  );

  spi_host_fifo #(.W(FRAME), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (xfer_done),
    .wdata        (rx_byte),
    .pop          (rd_data),
    .rdata        (fifo_head),
    .empty        (fifo_empty),
    .nonempty_nxt (nonempty_nxt),
    .dropped      (fifo_drop)
  );

  spi_host_irq u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_fall      (en_fall),
    .ctrl_b_wr    (wr_ctrl_b),
    .xfer_done    (xfer_done),
    .data_rd      (rd_data),
    .data_wr      (wr_data),
    .rd_hit       (!fifo_empty),
    .txeie_nxt    (wr_ctrl_b ? bus_wdata[7] : ctrl_b[7]),
    .rxneie_nxt   (wr_ctrl_b ? bus_wdata[6] : ctrl_b[6]),
    .nonempty_nxt (nonempty_nxt),
    .irq          (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a    <= '0;
      ctrl_b    <= '0;
      poly_q    <= 16'h0007;
      aud_cfg   <= '0;
      aud_pre   <= 10'h002;
      ovf       <= 1'b0;
      ovf_armed <= 1'b0;
      dma_q     <= 1'b0;
    end else begin
      if (wr_ctrl_a) ctrl_a <= bus_wdata[15:0];
      if (wr_ctrl_b) ctrl_b <= bus_wdata[7:0];
      if (bus_en && bus_we && widx == WI_POLY)   poly_q  <= bus_wdata[15:0];
      if (bus_en && bus_we && widx == WI_AUDCFG) aud_cfg <= bus_wdata[11:0] & 12'hBFF;
      if (bus_en && bus_we && widx == WI_AUDPRE) aud_pre <= bus_wdata[9:0];
      if (rd_data && ovf_armed) begin
        ovf       <= 1'b0;
        ovf_armed <= 1'b0;
      end
      if (rd_stat && ovf) ovf_armed <= 1'b1;
      if (fifo_drop)      ovf       <= 1'b1;
      dma_q <= xfer_done && ctrl_b[0];
    end
  end

  assign dma_rx_req = dma_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (widx)
        WI_CTRL_A: bus_rdata = {16'h0, ctrl_a};
        WI_CTRL_B: bus_rdata = {24'h0, ctrl_b};
        WI_STAT:   bus_rdata = {25'h0, ovf, 4'h0, !busy, !fifo_empty};
        WI_DATA:   bus_rdata = 32'(fifo_head);
        WI_POLY:   bus_rdata = {16'h0, poly_q};
        WI_AUDCFG: bus_rdata = {20'h0, aud_cfg};
        WI_AUDPRE: bus_rdata = {22'h0, aud_pre};
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_b[7] || (!fifo_empty && ctrl_b[6])));
  // R11
  irq_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !xfer_done) |=> !irq);
  // R12
  dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> $past(xfer_done));
  // R12
  dma_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |=> !dma_rx_req);
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> ovf);

endmodule

// File: tb/sim_spi_master_mmio.sv
module sim_spi_master_mmio;
  localparam logic [9:0] A_CTA = 10'h000, A_CTB = 10'h004, A_ST = 10'h008,
                         A_DAT = 10'h00C, A_POLY = 10'h010, A_RXS = 10'h014,
                         A_TXS = 10'h018, A_ACF = 10'h01C, A_APR = 10'h020;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso, irq, dma_rx_req;

  always #10 clk = ~clk;

  spi_master_mmio u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq), .dma_rx_req(dma_rx_req)
  );

  int vectors = 0, misses = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- serial slave model ----------------
  logic       m_cpol = 0, m_cpha = 0, m_lsb = 0;
  logic [7:0] sl_tx = 0, sl_rx = 0;
  int         sl_bit = 0, sl_edges = 0;
  logic       prev_sck = 0;

  function automatic logic pick(input logic [7:0] b, input int i, input logic lsb);
    return lsb ? b[i] : b[7 - i];
  endfunction

  always @(negedge clk) begin
    if (sck !== prev_sck) begin
      if ((sck != m_cpol) ? !m_cpha : m_cpha)
        sl_rx = m_lsb ? {mosi, sl_rx[7:1]} : {sl_rx[6:0], mosi};
      else if (!(m_cpha && sl_edges == 0)) begin
        sl_bit++;
        if (sl_bit < 8) miso = pick(sl_tx, sl_bit, m_lsb);
      end
      sl_edges++;
    end
    prev_sck = sck;
  end

  int dma_cnt = 0, dma_dbl = 0;
  logic dma_prev = 0;
  always @(negedge clk) begin
    if (dma_rx_req) dma_cnt++;
    if (dma_rx_req && dma_prev) dma_dbl++;
    dma_prev = dma_rx_req;
  end

  // ---------------- bus tasks (entered at a falling edge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic cpha, input logic cpol,
                                            input logic lsb, input int div, input logic en);
    return 32'(cpha) | (32'(cpol) << 1) | 32'h4 | (32'(div) << 3) | (32'(en) << 6) | (32'(lsb) << 7);
  endfunction

  function automatic int busy_cycles(input int div);
    return 16 * (1 << div);
  endfunction

  function automatic logic [31:0] stat_word(input int cnt, input logic ov);
    return (32'(ov) << 6) | 32'h2 | 32'(cnt != 0);
  endfunction

  int cur_div = 0;

  task automatic set_mode(input logic cpha, input logic cpol, input logic lsb, input int div);
    m_cpha = cpha; m_cpol = cpol; m_lsb = lsb; cur_div = div;
    bus_write(A_CTA, ctrl_word(cpha, cpol, lsb, div, 1'b1));
    idle(2);
  endtask

  task automatic slave_arm(input logic [7:0] b);
    sl_tx = b; sl_rx = 0; sl_bit = 0; sl_edges = 0;
    miso = pick(b, 0, m_lsb);
    prev_sck = sck;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sb);
    slave_arm(sb);
    bus_write(A_DAT, {24'h0, tx});
    idle(busy_cycles(cur_div) + 1);
  endtask

  // reference queue for the random phase
  logic [7:0] mq[$];
  logic mov = 0, marm = 0, mirq = 0;

  initial begin
    logic [31:0] r;
    logic [7:0]  tx, sb, held;
    int          n;
    miso = 0;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    bus_read(A_ST, r);  chk("R1 status", r, 32'h2);
    bus_read(A_CTA, r); chk("R1 ctrl1", r, 0);
    bus_read(A_CTB, r); chk("R1 ctrl2", r, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", dma_rx_req, 0);
    chk("R1 sck", sck, 0);

    // R2 register storage
    bus_write(A_CTB, 32'hFFFF_FF3E); bus_read(A_CTB, r); chk("R2 ctrl2", r, 32'h3E);
    bus_write(A_CTB, 0);
    bus_read(A_POLY, r); chk("R2 poly reset", r, 32'h7);
    bus_write(A_POLY, 32'h1234_5678); bus_read(A_POLY, r); chk("R2 poly", r, 32'h5678);
    bus_read(A_APR, r); chk("R2 pre reset", r, 32'h2);
    bus_write(A_APR, 32'hFFFF); bus_read(A_APR, r); chk("R2 pre", r, 32'h3FF);
    bus_read(A_RXS, r); chk("R2 rxsum", r, 0);
    bus_read(A_TXS, r); chk("R2 txsum", r, 0);
    bus_read(10'h3FC, r); chk("R2 unmapped", r, 0);
    bus_write(A_CTA, 32'h0001_FC00); bus_read(A_CTA, r); chk("R2 ctrl1", r, 32'hFC00);
    bus_write(A_CTA, 0);

    // R3 audio config enable bit stays 0
    bus_write(A_ACF, 32'hFFF); bus_read(A_ACF, r); chk("R3 cfg", r, 32'hBFF);

    // R4 directed exchange, busy window
    set_mode(0, 0, 0, 0);
    slave_arm(8'hA5);
    bus_write(A_DAT, 32'h3C);
    n = 0;
    do begin bus_read(A_ST, r); if (!r[1]) n++; end while (!r[1] && n < 200);
    chk("R4 busy cycles", n, busy_cycles(0));
    idle(1);
    chk("R4 mosi byte", sl_rx, 8'h3C);
    bus_read(A_ST, r); chk("R6 rxne", r, 32'h3);
    bus_read(A_DAT, r); chk("R6 data", r, 32'hA5);
    bus_read(A_ST, r); chk("R6 empty", r, 32'h2);

    // R5 every mode, random divider and bytes
    for (int m = 0; m < 8; m++) begin
      tx = 8'($urandom); sb = 8'($urandom);
      set_mode(m[0], m[1], m[2], int'($urandom % 3));
      chk("R5 idle level", sck, m[1]);
      xfer(tx, sb);
      chk("R5 sent", sl_rx, tx);
      bus_read(A_DAT, r); chk("R5 received", r, {24'h0, sb});
      chk("R5 idle after", sck, m[1]);
    end

    // R7 empty read
    bus_read(A_DAT, r); chk("R7 empty data", r, 0);
    bus_read(A_ST, r);  chk("R7 status", r, 32'h2);

    // R8 write while busy is dropped
    set_mode(0, 0, 0, 2);
    slave_arm(8'h5A);
    bus_write(A_DAT, 32'h11);
    idle(5);
    bus_write(A_DAT, 32'h22);
    idle(busy_cycles(2) + 4);
    chk("R8 sent first", sl_rx, 8'h11);
    bus_read(A_DAT, r); chk("R8 data", r, 32'h5A);
    bus_read(A_ST, r);  chk("R8 single entry", r, 32'h2);

    // R9 overflow
    set_mode(0, 0, 0, 0);
    for (int i = 0; i < 5; i++) xfer(8'($urandom), 8'(8'h10 + i));
    bus_read(A_DAT, r); chk("R9 head", r, 32'h10);
    bus_read(A_ST, r);  chk("R9 ovf sticky", r, 32'h43);
    bus_read(A_DAT, r); chk("R9 second", r, 32'h11);
    bus_read(A_ST, r);  chk("R9 ovf cleared", r, 32'h3);
    bus_read(A_DAT, r); chk("R9 third", r, 32'h12);
    bus_read(A_DAT, r); chk("R9 fourth", r, 32'h13);
    bus_read(A_ST, r);  chk("R9 drained", r, 32'h2);

    // R10 / R11 interrupt
    bus_write(A_CTB, 32'h40); chk("R10 ctrl2 eval", irq, 0);
    xfer(8'h01, 8'h81); chk("R10 after xfer", irq, 1);
    bus_read(A_DAT, r); chk("R10 pop last", irq, 0);
    xfer(8'h02, 8'h82); xfer(8'h03, 8'h83);
    bus_read(A_DAT, r); chk("R10 pop keeps", irq, 1);
    slave_arm(8'h84);
    bus_write(A_DAT, 32'h04); chk("R11 write drops", irq, 0);
    idle(busy_cycles(0) + 1); chk("R10 done raises", irq, 1);
    bus_write(A_CTA, ctrl_word(0, 0, 0, 0, 1'b0)); chk("R11 disable drops", irq, 0);
    bus_read(A_DAT, r); chk("R10 pop reeval", irq, 1);
    bus_read(A_DAT, r); chk("R10 pop to empty", irq, 0);
    bus_write(A_CTB, 32'h80); chk("R10 txeie", irq, 1);
    bus_read(A_DAT, r); chk("R11 empty read drops", irq, 0);
    bus_write(A_CTB, 0);

    // R12 DMA pulses
    set_mode(0, 0, 0, 0);
    bus_write(A_CTB, 32'h1);
    dma_cnt = 0; dma_dbl = 0;
    xfer(8'h0F, 8'h55); xfer(8'hF0, 8'hAA);
    chk("R12 pulses", dma_cnt, 2);
    chk("R12 width", dma_dbl, 0);
    bus_write(A_CTB, 0);
    dma_cnt = 0;
    xfer(8'h33, 8'h66);
    chk("R12 disabled", dma_cnt, 0);
    bus_read(A_DAT, r); bus_read(A_DAT, r); bus_read(A_DAT, r);

    // R13 completion and data read on the same edge
    bus_write(A_CTB, 32'h40);
    xfer(8'h44, 8'hC3);
    slave_arm(8'h3D);
    bus_write(A_DAT, 32'h99);
    idle(busy_cycles(0) - 1);
    bus_read(A_DAT, r); chk("R13 old head", r, 32'hC3);
    chk("R13 irq", irq, 1);
    bus_read(A_ST, r);  chk("R13 still queued", r, 32'h3);
    bus_read(A_DAT, r); chk("R13 new byte", r, 32'h3D);

    // random phase against a reference queue (R6 R9 R10)
    mq.delete(); mov = 0; marm = 0; mirq = 0;
    bus_write(A_CTB, 32'h40);
    for (int k = 0; k < 60; k++) begin
      int op;
      op = int'($urandom % 4);
      if (op < 2) begin
        if ($urandom % 4 == 0)
          set_mode(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 2));
        tx = 8'($urandom); sb = 8'($urandom);
        xfer(tx, sb);
        chk("R4 random sent", sl_rx, tx);
        if (mq.size() < 4) mq.push_back(sb); else mov = 1;
        mirq = (mq.size() != 0);
      end else if (op == 2) begin
        held = (mq.size() != 0) ? mq[0] : 8'h0;
        bus_read(A_DAT, r); chk("R6 random data", r, {24'h0, held});
        if (mq.size() != 0) begin void'(mq.pop_front()); mirq = (mq.size() != 0); end
        else mirq = 0;
        if (marm) begin mov = 0; marm = 0; end
      end else begin
        bus_read(A_ST, r); chk("R9 random status", r, stat_word(mq.size(), mov));
        if (mov) marm = 1;
      end
      chk("R10 random irq", irq, mirq);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++; misses++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule